// File: doc/BRIEF.md
# Bidirectional Parity-Checking Bus Transceiver

This block sits between two eight-bit data ports, called A and B, and passes data across in one direction at a time. A direction input picks which side drives: high sends A onto B (transmit), low sends B onto A (receive). An active-high disable input releases every driver the block owns, whatever the direction. Each bus pin is modelled as three separate signals: an input vector, an output vector and an output enable. A pad ring or a test model can join them into real tri-state pins.

A single parity pin changes role with the direction. In transmit, the block drives a parity bit. This bit makes the nine bits (the A data plus the parity bit) carry the sense chosen on the odd-select input. In receive, the pin is an input. The block checks it together with the B data, and an active-low error flag drops when the sense is wrong. The logic is purely combinational, so every output follows its inputs with no clock.

Top module: `bidir_parity_xcvr`

## Requirements
- R1: With the disable input low and the direction input high, `b_oe` is 1 and `a_oe` is 0.
- R2: With the disable input low and the direction input low, `a_oe` is 1 and `b_oe` is 0.
- R3: With the disable input high, `a_oe`, `b_oe` and `par_oe` are all 0 for either direction.
- R4: The data path does not invert: `b_out` equals `a_in` and `a_out` equals `b_in` bit for bit.
- R5: In transmit, `par_out` is chosen so that the number of ones in `a_in` plus `par_out` is odd when `odd_sel` is 1 and even when `odd_sel` is 0. For example, even sense with five ones gives 1.
- R6: `par_oe` is 1 exactly when the disable input is low and the direction input is high.
- R7: In receive with the block enabled, `err_n` is 0 exactly when the number of ones in `b_in` plus `par_in` fails the sense set by `odd_sel` (1 = odd). For example, odd sense, `par_in` = 1 and three ones gives 0.
- R8: `err_n` is 1 whenever the direction input is high or the disable input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_tx | input | 1 | 1 = transmit A to B, 0 = receive B to A |
| hiz_all | input | 1 | 1 releases all block drivers |
| odd_sel | input | 1 | 1 = odd parity sense, 0 = even |
| a_in | input | 8 | Value seen on port A pins |
| a_out | output | 8 | Value the block drives onto port A |
| a_oe | output | 1 | Driver enable for port A |
| b_in | input | 8 | Value seen on port B pins |
| b_out | output | 8 | Value the block drives onto port B |
| b_oe | output | 1 | Driver enable for port B |
| par_in | input | 1 | Value seen on the parity pin |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Driver enable for the parity pin |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The bench sweeps every 8-bit data value against every combination of direction, disable, sense and incoming parity. It computes the expected results by counting ones in the bench. The parity cases target a reversed sense or an extra inversion, either of which would flip every generated bit and every error flag. They also catch a check that ignores the incoming parity bit, which would disagree on half of the receive cases. The enable cases catch a parity driver left on during receive or while disabled, which would fight the external parity source. They also catch an error flag that stays live in transmit and reports errors that do not exist.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int unsigned DATA_W = 8;

    typedef struct packed {
        logic a_oe;
        logic b_oe;
        logic par_oe;
        logic chk_en;
    } drv_t;
endpackage

// File: rtl/xor_reduce.sv
module xor_reduce #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] bits_in,
    output logic         odd_ones
);
    logic [W:0] chain;
    assign chain[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_stage
        assign chain[i+1] = chain[i] ^ bits_in[i];
    end
    assign odd_ones = chain[W];
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
    import xcvr_pkg::*;
(
    input  logic dir_tx,
    input  logic hiz_all,
    output drv_t drv
);
    drv_t drv_d;

    always_comb begin
        drv_d = '0;
        if (!hiz_all) begin
            if (dir_tx) begin
                drv_d.b_oe   = 1'b1;
                drv_d.par_oe = 1'b1;
            end else begin
                drv_d.a_oe   = 1'b1;
                drv_d.chk_en = 1'b1;
            end
        end
    end

    assign drv = drv_d;

    always_comb begin
        // R1
        no_dual_drive_chk: assert (!(drv_d.a_oe && drv_d.b_oe));
        // R3
        hiz_release_chk: assert (!hiz_all || (drv_d.a_oe == 1'b0 && drv_d.b_oe == 1'b0 && drv_d.par_oe == 1'b0));
        // R6
        par_with_b_chk: assert (drv_d.par_oe == drv_d.b_oe);
    end
endmodule

// File: rtl/bidir_parity_xcvr.sv
module bidir_parity_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         dir_tx,
    input  logic         hiz_all,
    input  logic         odd_sel,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         par_in,
    output logic         par_out,
    output logic         par_oe,
    output logic         err_n
);
    drv_t drv;
    logic a_odd;
    logic rx_odd;

    dir_ctrl u_ctrl (
        .dir_tx  (dir_tx),
        .hiz_all (hiz_all),
        .drv     (drv)
    );

    xor_reduce #(.W(W)) u_tx_par (
        .bits_in  (a_in),
        .odd_ones (a_odd)
    );

    xor_reduce #(.W(W + 1)) u_rx_par (
        .bits_in  ({par_in, b_in}),
        .odd_ones (rx_odd)
    );

    typedef struct packed {
        logic [W-1:0] a_out;
        logic [W-1:0] b_out;
        logic         par;
        logic         err_n;
    } out_t;

    out_t out_d;

    always_comb begin
        out_d.a_out = b_in;
        out_d.b_out = a_in;
        out_d.par   = a_odd ^ odd_sel;
        out_d.err_n = 1'b1;
        if (drv.chk_en) begin
            out_d.err_n = (rx_odd == odd_sel);
        end
    end

    assign a_out   = out_d.a_out;
    assign b_out   = out_d.b_out;
    assign par_out = out_d.par;
    assign err_n   = out_d.err_n;
    assign a_oe    = drv.a_oe;
    assign b_oe    = drv.b_oe;
    assign par_oe  = drv.par_oe;

    always_comb begin
        // R8
        err_only_rx_chk: assert (err_n || (!dir_tx && !hiz_all));
        // R5
        tx_sense_chk: assert ((a_odd ^ par_out) == odd_sel);
        // R2
        rx_drives_a_chk: assert (hiz_all || dir_tx || (a_oe && !b_oe));
    end
endmodule

// File: tb/bidir_parity_xcvr_tb.sv
module bidir_parity_xcvr_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       dir_tx, hiz_all, odd_sel, par_in;
    logic [7:0] a_in, b_in;
    logic [7:0] a_out, b_out;
    logic       a_oe, b_oe, par_out, par_oe, err_n;

    int checks = 0;
    int fails  = 0;

    bidir_parity_xcvr u_dut (
        .dir_tx  (dir_tx),
        .hiz_all (hiz_all),
        .odd_sel (odd_sel),
        .a_in    (a_in),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_in    (b_in),
        .b_out   (b_out),
        .b_oe    (b_oe),
        .par_in  (par_in),
        .par_out (par_out),
        .par_oe  (par_oe),
        .err_n   (err_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (dir=%0d hiz=%0d odd=%0d a=%02h b=%02h p=%0d)",
                     req, act, exp, dir_tx, hiz_all, odd_sel, a_in, b_in, par_in);
        end
    endtask

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic apply(input bit d, input bit h, input bit o, input bit p,
                         input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        dir_tx = d; hiz_all = h; odd_sel = o; par_in = p; a_in = a; b_in = b;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Fixed examples first
        apply(1'b1, 1'b0, 1'b0, 1'b0, 8'b0001_1111, 8'h00);
        check(par_out == 1'b1, "R5 even five ones", par_out, 1);
        apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'b0000_0111);
        check(err_n == 1'b0, "R7 odd three ones par1", err_n, 0);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        check({a_oe, b_oe, par_oe} == 3'b000, "R3 idle disabled", {a_oe, b_oe, par_oe}, 0);

        for (int d = 0; d < 2; d++)
        for (int h = 0; h < 2; h++)
        for (int o = 0; o < 2; o++)
        for (int p = 0; p < 2; p++)
        for (int v = 0; v < 256; v++) begin
            logic [7:0] av, bv;
            int exp_par, exp_err, exp_aoe, exp_boe, exp_poe;
            av = 8'(v);
            bv = 8'(((v * 37) + 11 + p * 64) & 255);
            apply(1'(d), 1'(h), 1'(o), 1'(p), av, bv);
            exp_par = ((ones(av) % 2) == 1) ? (o == 1 ? 0 : 1) : (o == 1 ? 1 : 0);
            exp_aoe = (h == 0 && d == 0) ? 1 : 0;
            exp_boe = (h == 0 && d == 1) ? 1 : 0;
            exp_poe = exp_boe;
            if (d == 0 && h == 0)
                exp_err = (((ones(bv) + p) % 2) == o) ? 1 : 0;
            else
                exp_err = 1;
            check(b_out == av, "R4 b_out", b_out, av);
            check(a_out == bv, "R4 a_out", a_out, bv);
            if (d == 1) check(int'(par_out) == exp_par, "R5 parity", par_out, exp_par);
            check(int'(par_oe) == exp_poe, "R6 par_oe", par_oe, exp_poe);
            if (h == 1) begin
                check({a_oe, b_oe, par_oe} == 3'b000, "R3 released", {a_oe, b_oe, par_oe}, 0);
            end else if (d == 1) begin
                check(int'(b_oe) == exp_boe && int'(a_oe) == exp_aoe, "R1 tx enables", {a_oe, b_oe}, {exp_aoe[0], exp_boe[0]});
            end else begin
                check(int'(a_oe) == exp_aoe && int'(b_oe) == exp_boe, "R2 rx enables", {a_oe, b_oe}, {exp_aoe[0], exp_boe[0]});
            end
            if (d == 0 && h == 0)
                check(int'(err_n) == exp_err, "R7 err_n", err_n, exp_err);
            else
                check(err_n == 1'b1, "R8 err_n idle", err_n, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule